// File: doc/BRIEF.md
# Message Queue Unit

The block holds four first-in first-out lists of 32-bit message words that let a host and a local processor pass messages both ways: an inbound post list, an inbound free list, an outbound post list and an outbound free list. A host reaches them through a small register bus with two data windows. The same window address touches a different list depending on whether the host writes or reads it. A write to the inbound window posts a message, and a read from it takes a free buffer word. A write to the outbound window returns a free word, and a read from it collects a posted message. A control register holds an enable bit and a 3-bit depth code.

A second, local-side port does the opposite half of each exchange. It drains the two post lists and refills the two free lists, and it works whether or not the host side is enabled. Each list reports empty, full and a sticky overflow flag.

The physical storage is sized for the largest depth code. The smallest logical depth is 2^BASE_LOG2 entries and each code step doubles it. A production build sets BASE_LOG2 to 8, which gives 256 to 32K entries. The default of 2 keeps simulation storage small.

Top module: `mq_unit`

## Requirements
- R1: After reset the enable bit and depth code are 0, all four lists are empty, no full or overflow flag is set, no acknowledge is pending, and a read of the control register returns 0.
- R2: Address 48h is the control register: bit 0 is the enable and bits 3:1 are the depth code, and a read returns them in those positions. A control write whose depth code differs from the current one empties all four lists and clears their overflow flags. A control write that keeps the code leaves the lists untouched.
- R3: With the enable set, a host write to 40h appends the data to the inbound post list, and a host read of 40h removes and returns the oldest word of the inbound free list.
- R4: With the enable set, a host write to 44h appends the data to the outbound free list, and a host read of 44h removes and returns the oldest word of the outbound post list.
- R5: With the enable clear, host writes to 40h and 44h are acknowledged and change no list, and host reads of them are acknowledged, return FFFFFFFFh and remove nothing.
- R6: Every host or local request, held for one cycle, is acknowledged in the following cycle, with its read data valid in that same cycle. A host read of any address other than 40h, 44h and 48h returns 0.
- R7: The logical depth of each list is 2^(BASE_LOG2 + depth code) entries, and its full flag is set exactly when it holds that many words.
- R8: A read that targets an empty list returns FFFFFFFFh and leaves the list unchanged.
- R9: A push into a full list is acknowledged and dropped, and it sets that list's overflow flag. The flag stays set until a control write changes the depth code.
- R10: On the local port, direction 0 writes append to the inbound free list and reads pop the inbound post list. Direction 1 writes append to the outbound post list and reads pop the outbound free list. The local port works regardless of the enable bit.
- R11: Each list returns words in the order they were appended.
- R12: Status vectors use bit 0 for inbound post, bit 1 for inbound free, bit 2 for outbound post and bit 3 for outbound free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Host access request, one cycle per access |
| bus_wr | input | 1 | Host access is a write |
| bus_addr | input | 8 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_ack | output | 1 | Host access done, one cycle after request |
| bus_rdata | output | 32 | Host read data, valid with bus_ack |
| loc_req | input | 1 | Local access request |
| loc_wr | input | 1 | Local access is a write (refill) |
| loc_dir | input | 1 | Local direction: 0 inbound, 1 outbound |
| loc_wdata | input | 32 | Local write data |
| loc_ack | output | 1 | Local access done |
| loc_rdata | output | 32 | Local read data, valid with loc_ack |
| q_empty | output | 4 | Per-list empty flags |
| q_full | output | 4 | Per-list full flags |
| q_ovf | output | 4 | Per-list sticky overflow flags |

## Verification
The main exchange is driven in three patterns. The first is a round trip through all four lists with the host and local sides taking turns, which shows that each window routes writes and reads to different lists. The second fills a list to its limit under two depth codes, which separates a correct wrap point from one that is off by one or ignores the code. The third accesses the windows with the enable clear, then sets the enable and reads back a word stored earlier, which shows that a disabled read neither returns data nor pops. Empty reads, overflow stickiness and the flush on a depth change cover the remaining boundaries.

// File: rtl/mq_pkg.sv
package mq_pkg;
    localparam int DW     = 32;
    localparam int ADDR_W = 8;
    localparam int NQ     = 4;

    localparam logic [ADDR_W-1:0] ADDR_INB  = 8'h40;
    localparam logic [ADDR_W-1:0] ADDR_OUTB = 8'h44;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h48;

    typedef enum logic [1:0] {
        Q_IN_POST  = 2'd0,
        Q_IN_FREE  = 2'd1,
        Q_OUT_POST = 2'd2,
        Q_OUT_FREE = 2'd3
    } qid_e;

    typedef struct packed {
        logic [2:0] size;
        logic       en;
    } ctrl_t;

    // host side feeds the inbound post and outbound free lists
    function automatic logic fed_by_host(input int q);
        return (q == int'(Q_IN_POST)) || (q == int'(Q_OUT_FREE));
    endfunction
endpackage

// File: rtl/mq_queue.sv
module mq_queue
    import mq_pkg::*;
#(
    parameter int BASE_LOG2 = 2,
    localparam int AW   = BASE_LOG2 + 7,
    localparam int CW   = AW + 1,
    localparam int PHYS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [2:0]    size_code,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          empty,
    output logic          full,
    output logic          ovf
);
    logic [DW-1:0] mem [PHYS];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count, depth;
    logic          do_push, do_pop;

    always_comb begin
        depth   = CW'(1) << (BASE_LOG2 + int'(size_code));
        empty   = (count == '0);
        full    = (count == depth);
        do_push = push && !full;
        do_pop  = pop && !empty;
        pop_data = mem[rp];
    end

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [CW-1:0] d);
        return ({1'b0, p} == d - CW'(1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wp <= step(wp, depth);
            if (do_pop)  rp <= step(rp, depth);
            count <= count + CW'(do_push) - CW'(do_pop);
            if (push && full) ovf <= 1'b1;
        end
    end

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        push && full && !pop && !clr |=> full && ovf);
    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        pop && empty && !push && !clr |=> empty);
    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= depth);
endmodule

// File: rtl/mq_route.sv
module mq_route
    import mq_pkg::*;
(
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              en,
    input  logic              loc_req,
    input  logic              loc_wr,
    input  logic              loc_dir,
    output logic [NQ-1:0]     push,
    output logic [NQ-1:0]     pop,
    output logic              ctrl_wr
);
    logic hin, hout;

    always_comb begin
        hin     = bus_req && en && (bus_addr == ADDR_INB);
        hout    = bus_req && en && (bus_addr == ADDR_OUTB);
        ctrl_wr = bus_req && bus_wr && (bus_addr == ADDR_CTRL);
        push = '0;
        pop  = '0;
        push[Q_IN_POST]  = hin && bus_wr;
        pop[Q_IN_FREE]   = hin && !bus_wr;
        push[Q_OUT_FREE] = hout && bus_wr;
        pop[Q_OUT_POST]  = hout && !bus_wr;
        push[Q_IN_FREE]  = loc_req && loc_wr && !loc_dir;
        push[Q_OUT_POST] = loc_req && loc_wr && loc_dir;
        pop[Q_IN_POST]   = loc_req && !loc_wr && !loc_dir;
        pop[Q_OUT_FREE]  = loc_req && !loc_wr && loc_dir;
    end
endmodule

// File: rtl/mq_unit.sv
module mq_unit
    import mq_pkg::*;
#(
    parameter int BASE_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic              bus_ack,
    output logic [DW-1:0]     bus_rdata,
    input  logic              loc_req,
    input  logic              loc_wr,
    input  logic              loc_dir,
    input  logic [DW-1:0]     loc_wdata,
    output logic              loc_ack,
    output logic [DW-1:0]     loc_rdata,
    output logic [NQ-1:0]     q_empty,
    output logic [NQ-1:0]     q_full,
    output logic [NQ-1:0]     q_ovf
);
    ctrl_t         cfg;
    logic [NQ-1:0] push, pop;
    logic          ctrl_wr, flush;
    logic [DW-1:0] qdata [NQ];
    logic [DW-1:0] bus_nxt, loc_nxt;

    mq_route route_i (
        .bus_req (bus_req),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .en      (cfg.en),
        .loc_req (loc_req),
        .loc_wr  (loc_wr),
        .loc_dir (loc_dir),
        .push    (push),
        .pop     (pop),
        .ctrl_wr (ctrl_wr)
    );

    assign flush = ctrl_wr && (bus_wdata[3:1] != cfg.size);

    for (genvar q = 0; q < NQ; q++) begin : g_q
        localparam bit HOST = fed_by_host(q);
        mq_queue #(.BASE_LOG2(BASE_LOG2)) queue_i (
            .clk      (clk),
            .rst      (rst),
            .clr      (flush),
            .size_code(cfg.size),
            .push     (push[q]),
            .push_data(HOST ? bus_wdata : loc_wdata),
            .pop      (pop[q]),
            .pop_data (qdata[q]),
            .empty    (q_empty[q]),
            .full     (q_full[q]),
            .ovf      (q_ovf[q])
        );
    end

    always_comb begin
        bus_nxt = '0;
        if (!bus_wr) begin
            unique case (bus_addr)
                ADDR_INB:  bus_nxt = (cfg.en && !q_empty[Q_IN_FREE])  ? qdata[Q_IN_FREE]  : '1;
                ADDR_OUTB: bus_nxt = (cfg.en && !q_empty[Q_OUT_POST]) ? qdata[Q_OUT_POST] : '1;
                ADDR_CTRL: bus_nxt = DW'(cfg);
                default:   bus_nxt = '0;
            endcase
        end
        loc_nxt = '0;
        if (!loc_wr) begin
            if (loc_dir) loc_nxt = q_empty[Q_OUT_FREE] ? '1 : qdata[Q_OUT_FREE];
            else         loc_nxt = q_empty[Q_IN_POST]  ? '1 : qdata[Q_IN_POST];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            loc_ack   <= 1'b0;
            loc_rdata <= '0;
        end else begin
            if (ctrl_wr) cfg <= ctrl_t'(bus_wdata[3:0]);
            bus_ack   <= bus_req;
            bus_rdata <= bus_req ? bus_nxt : '0;
            loc_ack   <= loc_req;
            loc_rdata <= loc_req ? loc_nxt : '0;
        end
    end

    // R6
    ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> bus_ack);
    // R6
    loc_ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
        loc_req |=> loc_ack);
    // R5
    disabled_read_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_wr && !cfg.en && (bus_addr == ADDR_INB || bus_addr == ADDR_OUTB)
        |=> bus_rdata == '1);
    // R5
    disabled_write_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_wr && !cfg.en && bus_addr == ADDR_INB && !loc_req
        |=> $stable(q_empty[Q_IN_POST]) && $stable(q_full[Q_IN_POST]));
endmodule

// File: tb/mq_unit_tb_top.sv
module mq_unit_tb_top;
    import mq_pkg::*;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_req = 1'b0, bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ack;
    logic [31:0]   bus_rdata;
    logic          loc_req = 1'b0, loc_wr = 1'b0, loc_dir = 1'b0;
    logic [31:0]   loc_wdata = '0;
    logic          loc_ack;
    logic [31:0]   loc_rdata;
    logic [3:0]    q_empty, q_full, q_ovf;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mq_unit dut_i (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .loc_req(loc_req), .loc_wr(loc_wr), .loc_dir(loc_dir),
        .loc_wdata(loc_wdata), .loc_ack(loc_ack), .loc_rdata(loc_rdata),
        .q_empty(q_empty), .q_full(q_full), .q_ovf(q_ovf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        check("R6 host ack", 32'(bus_ack), 32'd1);
        rd = bus_rdata;
    endtask

    task automatic local_op(input logic wr, input logic dir, input logic [31:0] d,
                            output logic [31:0] rd);
        @(negedge clk);
        loc_req = 1'b1; loc_wr = wr; loc_dir = dir; loc_wdata = d;
        @(negedge clk);
        loc_req = 1'b0;
        check("R6 local ack", 32'(loc_ack), 32'd1);
        rd = loc_rdata;
    endtask

    // fields: local, write, address (bit 0 = direction when local), data, expected read
    localparam int NV = 14;
    localparam logic [73:0] VEC [NV] = '{
        {1'b0, 1'b1, 8'h48, 32'h0000_0001, 32'h0},          // R2 enable, same depth
        {1'b0, 1'b1, 8'h40, 32'hA000_0001, 32'h0},          // R3 inbound post
        {1'b0, 1'b1, 8'h40, 32'hA000_0002, 32'h0},
        {1'b1, 1'b0, 8'h00, 32'h0,         32'hA000_0001},  // R10 R11
        {1'b1, 1'b0, 8'h00, 32'h0,         32'hA000_0002},  // R11
        {1'b1, 1'b0, 8'h00, 32'h0,         32'hFFFF_FFFF},  // R8
        {1'b1, 1'b1, 8'h00, 32'hB000_0001, 32'h0},          // R10 inbound free
        {1'b0, 1'b0, 8'h40, 32'h0,         32'hB000_0001},  // R3
        {1'b0, 1'b0, 8'h40, 32'h0,         32'hFFFF_FFFF},  // R8
        {1'b1, 1'b1, 8'h01, 32'hC000_0001, 32'h0},          // R10 outbound post
        {1'b0, 1'b0, 8'h44, 32'h0,         32'hC000_0001},  // R4
        {1'b0, 1'b1, 8'h44, 32'hD000_0001, 32'h0},          // R4 outbound free
        {1'b1, 1'b0, 8'h01, 32'h0,         32'hD000_0001},  // R10
        {1'b0, 1'b0, 8'h48, 32'h0,         32'h0000_0001}   // R2 readback
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 empty", 32'(q_empty), 32'hF);
        check("R1 full", 32'(q_full), 32'h0);
        check("R1 ovf", 32'(q_ovf), 32'h0);
        check("R1 ack idle", 32'(bus_ack), 32'h0);
        host(1'b0, 8'h48, 32'h0, rd);
        check("R1 ctrl", rd, 32'h0);
        host(1'b0, 8'h50, 32'h0, rd);
        check("R6 unmapped read", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [73:0] v;
            v = VEC[i];
            if (v[73]) local_op(v[72], v[64], v[63:32], rd);
            else       host(v[72], v[71:64], v[63:32], rd);
            if (!v[72]) check($sformatf("R3/R4/R10 vector %0d", i), rd, v[31:0]);
        end

        // R12 status bit positions
        local_op(1'b1, 1'b1, 32'h1234, rd);
        check("R12 empty map", 32'(q_empty), 32'b1011);
        host(1'b0, 8'h44, 32'h0, rd);
        check("R4 drain", rd, 32'h1234);

        // R7 R9 fill at depth code 0 (4 entries)
        for (int k = 0; k < 4; k++) begin
            host(1'b1, 8'h40, 32'h100 + 32'(k), rd);
            if (k == 2) check("R7 not full at 3", 32'(q_full[0]), 32'h0);
        end
        check("R7 full at 4", 32'(q_full[0]), 32'h1);
        check("R9 no ovf yet", 32'(q_ovf[0]), 32'h0);
        host(1'b1, 8'h40, 32'hDEAD, rd);
        check("R9 ovf set", 32'(q_ovf[0]), 32'h1);
        for (int k = 0; k < 4; k++) begin
            local_op(1'b0, 1'b0, 32'h0, rd);
            check("R9 R11 order after drop", rd, 32'h100 + 32'(k));
        end
        local_op(1'b0, 1'b0, 32'h0, rd);
        check("R8 empty after drain", rd, 32'hFFFF_FFFF);
        check("R9 ovf sticky", 32'(q_ovf[0]), 32'h1);

        // R2 flush on depth change: leave one word, then code 1
        host(1'b1, 8'h40, 32'h77, rd);
        host(1'b1, 8'h48, 32'h3, rd);
        check("R2 flush empties", 32'(q_empty), 32'hF);
        check("R2 flush clears ovf", 32'(q_ovf), 32'h0);
        host(1'b0, 8'h48, 32'h0, rd);
        check("R2 ctrl readback", rd, 32'h3);

        // R7 code 1 gives 8 entries
        for (int k = 0; k < 8; k++) begin
            host(1'b1, 8'h40, 32'h200 + 32'(k), rd);
            if (k == 6) check("R7 not full at 7", 32'(q_full[0]), 32'h0);
        end
        check("R7 full at 8", 32'(q_full[0]), 32'h1);
        for (int k = 0; k < 8; k++) begin
            local_op(1'b0, 1'b0, 32'h0, rd);
            check("R7 R11 wrap order", rd, 32'h200 + 32'(k));
        end

        // R5 disabled, same depth code so no flush
        local_op(1'b1, 1'b0, 32'h5A5A, rd);
        host(1'b1, 8'h48, 32'h2, rd);
        host(1'b0, 8'h40, 32'h0, rd);
        check("R5 disabled read", rd, 32'hFFFF_FFFF);
        host(1'b1, 8'h40, 32'h9999, rd);
        host(1'b1, 8'h44, 32'h8888, rd);
        check("R5 disabled write dropped", 32'(q_empty[0]), 32'h1);
        check("R5 outbound free untouched", 32'(q_empty[3]), 32'h1);
        local_op(1'b1, 1'b1, 32'h6B6B, rd);
        check("R10 local works disabled", 32'(q_empty[2]), 32'h0);
        host(1'b1, 8'h48, 32'h3, rd);
        host(1'b0, 8'h40, 32'h0, rd);
        check("R5 disabled read did not pop", rd, 32'h5A5A);
        host(1'b0, 8'h44, 32'h0, rd);
        check("R4 after re-enable", rd, 32'h6B6B);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule